// File: doc/BRIEF.md
# Selectable Axis Matrix Reducer

This block takes one two-dimensional matrix per beat, ROWS by COLS unsigned elements (for example the per-range hit bits of a range filter widened to integers), and sums it along one axis. Which axis is chosen per beat by a single instruction bit that travels with the data. Summing across each row gives ROWS results. Summing down each column gives COLS results. A count output tells the consumer how many leading result lanes hold data.

Both edges use valid/ready handshakes. An accepted beat produces a registered result one cycle later. The result is held until the consumer takes it. The sums are wide enough that no input can overflow them. Result lanes past the valid count are driven to zero, so a downstream packer can take the lanes as they are.

Top module: `axis_sum_reducer`

## Requirements
- R1: With `in_axis` = 0, lane r of `out_sums` equals the sum of row r (elements r*COLS .. r*COLS+COLS-1), and `out_count` equals ROWS.
- R2: With `in_axis` = 1, lane c of `out_sums` equals the sum of column c (elements c, c+COLS, ..., c+(ROWS-1)*COLS), and `out_count` equals COLS.
- R3: Each lane is SUM_W = DATA_W + ceil(log2(max(ROWS,COLS))) bits wide. An all-ones matrix gives exact sums on both axes.
- R4: While `out_valid` is high, every lane with index at or above `out_count` is zero.
- R5: The axis bit is captured with its own beat. Changing `in_axis` between beats affects only the beats accepted after the change.
- R6: A beat accepted on a rising edge (`in_valid` and `in_ready` high) is presented with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_sums` and `out_count` stay stable and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R8: Synchronous active-high reset clears `out_valid`, `out_sums` and `out_count` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_mat | input | ROWS*COLS*DATA_W | Matrix, element (r,c) at bits [DATA_W*(r*COLS+c) +: DATA_W] |
| in_axis | input | 1 | 0: sum each row, 1: sum each column |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sums | output | LANES*SUM_W | Lane k at bits [SUM_W*k +: SUM_W], LANES = max(ROWS,COLS) |
| out_count | output | clog2(LANES+1) | Number of valid leading lanes |

## Verification
A ramp matrix with distinct values is reduced on both axes. Because it is not symmetric, swapped axes or transposed indexing give different numbers. A single-hot matrix moved across positions shows that each element lands in exactly one row lane and one column lane. All-ones data checks the top bit of every sum. Back-to-back beats with alternating axis bits, and a stalled consumer while a new beat waits, separate per-beat axis capture and hold behaviour from a design that samples the axis late or overwrites a held result.

// File: rtl/axr_pkg.sv
package axr_pkg;

  typedef enum logic {
    AXIS_ROWS = 1'b0,
    AXIS_COLS = 1'b1
  } axis_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/axr_vec_sum.sv
module axr_vec_sum #(
  parameter int unsigned ELEMS  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SUM_W  = 10
) (
  input  logic [ELEMS*DATA_W-1:0] vec,
  output logic [SUM_W-1:0]        sum
);

  always_comb begin
    sum = '0;
    for (int k = 0; k < ELEMS; k++) begin
      sum = sum + SUM_W'(vec[k*DATA_W +: DATA_W]);
    end
  end

endmodule

// File: rtl/axr_lane_select.sv
module axr_lane_select
  import axr_pkg::*;
#(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 3,
  parameter int unsigned SUM_W = 10,
  localparam int unsigned LANES = max2(ROWS, COLS),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [ROWS*SUM_W-1:0]  row_sums,
  input  logic [COLS*SUM_W-1:0]  col_sums,
  input  axis_e                  axis,
  output logic [LANES*SUM_W-1:0] lanes,
  output logic [CNT_W-1:0]       count
);

  localparam logic [CNT_W-1:0] CNT_ROWS = CNT_W'(ROWS);
  localparam logic [CNT_W-1:0] CNT_COLS = CNT_W'(COLS);

  assign count = (axis == AXIS_COLS) ? CNT_COLS : CNT_ROWS;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < ROWS && k < COLS) begin : g_both
      assign lanes[k*SUM_W +: SUM_W] = (axis == AXIS_COLS) ? col_sums[k*SUM_W +: SUM_W]
                                                           : row_sums[k*SUM_W +: SUM_W];
    end else if (k < ROWS) begin : g_row_only
      assign lanes[k*SUM_W +: SUM_W] = (axis == AXIS_ROWS) ? row_sums[k*SUM_W +: SUM_W]
                                                           : '0;
    end else begin : g_col_only
      assign lanes[k*SUM_W +: SUM_W] = (axis == AXIS_COLS) ? col_sums[k*SUM_W +: SUM_W]
                                                           : '0;
    end
  end

endmodule

// File: rtl/axis_sum_reducer.sv
module axis_sum_reducer
  import axr_pkg::*;
#(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANES = max2(ROWS, COLS),
  localparam int unsigned SUM_W = DATA_W + $clog2(LANES),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ROWS*COLS*DATA_W-1:0] in_mat,
  input  logic                        in_axis,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANES*SUM_W-1:0]      out_sums,
  output logic [CNT_W-1:0]            out_count
);

  logic [ROWS*SUM_W-1:0]  row_sums;
  logic [COLS*SUM_W-1:0]  col_sums;
  logic [LANES*SUM_W-1:0] lanes_next;
  logic [CNT_W-1:0]       count_next;
  logic                   accept;

  // one adder per row over a contiguous slice
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    axr_vec_sum #(.ELEMS(COLS), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_sum (
      .vec (in_mat[r*COLS*DATA_W +: COLS*DATA_W]),
      .sum (row_sums[r*SUM_W +: SUM_W])
    );
  end

  // one adder per column over a strided gather
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS*DATA_W-1:0] col_vec;
    for (genvar r = 0; r < ROWS; r++) begin : g_gather
      assign col_vec[r*DATA_W +: DATA_W] = in_mat[(r*COLS+c)*DATA_W +: DATA_W];
    end
    axr_vec_sum #(.ELEMS(ROWS), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_sum (
      .vec (col_vec),
      .sum (col_sums[c*SUM_W +: SUM_W])
    );
  end

  axr_lane_select #(.ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W)) u_sel (
    .row_sums (row_sums),
    .col_sums (col_sums),
    .axis     (axis_e'(in_axis)),
    .lanes    (lanes_next),
    .count    (count_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sums  <= '0;
      out_count <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_sums  <= lanes_next;
      out_count <= count_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/axis_sum_reducer_chk.sv
module axis_sum_reducer_chk
  import axr_pkg::*;
#(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANES = max2(ROWS, COLS),
  localparam int unsigned SUM_W = DATA_W + $clog2(LANES),
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [ROWS*COLS*DATA_W-1:0] in_mat,
  input logic                        in_axis,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [LANES*SUM_W-1:0]      out_sums,
  input logic [CNT_W-1:0]            out_count
);

  localparam logic [CNT_W-1:0] CNT_ROWS = CNT_W'(ROWS);
  localparam logic [CNT_W-1:0] CNT_COLS = CNT_W'(COLS);

  logic upper_nonzero;
  always_comb begin
    upper_nonzero = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (k >= int'(out_count) && out_sums[k*SUM_W +: SUM_W] != '0) upper_nonzero = 1'b1;
    end
  end

  // R1 and R2: count is one of the two legal lengths
  assert_count_legal_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count == CNT_ROWS || out_count == CNT_COLS));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !upper_nonzero);

  assert_axis_follows_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_count == ($past(in_axis) ? CNT_COLS : CNT_ROWS)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sums) && $stable(out_count)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind axis_sum_reducer axis_sum_reducer_chk #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/axis_sum_reducer_tb.sv
module axis_sum_reducer_tb;

  localparam int ROWS   = 4;
  localparam int COLS   = 3;
  localparam int DATA_W = 8;
  localparam int LANES  = (ROWS > COLS) ? ROWS : COLS;
  localparam int SUM_W  = DATA_W + $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES + 1);

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic                        in_valid = 1'b0;
  logic                        in_ready;
  logic [ROWS*COLS*DATA_W-1:0] in_mat = '0;
  logic                        in_axis = 1'b0;
  logic                        out_valid;
  logic                        out_ready = 1'b1;
  logic [LANES*SUM_W-1:0]      out_sums;
  logic [CNT_W-1:0]            out_count;

  axis_sum_reducer #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mat(in_mat), .in_axis(in_axis), .out_valid(out_valid),
    .out_ready(out_ready), .out_sums(out_sums), .out_count(out_count)
  );

  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R8";

  // reference model state
  bit m_valid = 1'b0;
  int m_count = 0;
  int m_lane [LANES];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int elem(int r, int c);
    return int'(in_mat[(r*COLS+c)*DATA_W +: DATA_W]);
  endfunction

  task automatic set_elem(int r, int c, int v);
    in_mat[(r*COLS+c)*DATA_W +: DATA_W] = DATA_W'(v);
  endtask

  task automatic model_step();
    if (rst) begin
      m_valid = 1'b0;
      m_count = 0;
      foreach (m_lane[k]) m_lane[k] = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid = 1'b1;
      foreach (m_lane[k]) m_lane[k] = 0;
      if (!in_axis) begin
        m_count = ROWS;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) m_lane[r] += elem(r, c);
      end else begin
        m_count = COLS;
        for (int c = 0; c < COLS; c++)
          for (int r = 0; r < ROWS; r++) m_lane[c] += elem(r, c);
      end
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic compare();
    check(out_valid == m_valid, cur_req, "out_valid", out_valid, m_valid);
    check(in_ready == (!m_valid || out_ready), "R7", "in_ready", in_ready,
          (!m_valid || out_ready));
    if (m_valid) begin
      check(int'(out_count) == m_count, cur_req, "out_count", out_count, m_count);
      for (int k = 0; k < LANES; k++) begin
        // lanes past the count are expected zero (R4)
        check(int'(out_sums[k*SUM_W +: SUM_W]) == m_lane[k],
              (k >= m_count) ? "R4" : cur_req, $sformatf("lane %0d", k),
              out_sums[k*SUM_W +: SUM_W], m_lane[k]);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input bit axis);
    in_valid = 1'b1;
    in_axis  = axis;
    tick();
    in_valid = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    cur_req = "R8";
    tick();
    tick();
    check(out_valid == 1'b0, "R8", "reset out_valid", out_valid, 0);
    check(out_sums == '0, "R8", "reset out_sums", 1, 0);
    check(out_count == '0, "R8", "reset out_count", out_count, 0);
    rst = 1'b0;
    tick();

    // R1 / R6: ramp matrix, row sums
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_elem(r, c, 10*r + 3*c + 1);
    cur_req = "R1";
    send(1'b0);
    tick();
    // R2: same ramp, column sums
    cur_req = "R2";
    send(1'b1);
    tick();

    // R3: all ones on both axes
    cur_req = "R3";
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_elem(r, c, (1 << DATA_W) - 1);
    send(1'b0);
    send(1'b1);
    tick();

    // R1 / R2: single hot element walked over positions
    for (int p = 0; p < ROWS*COLS; p += 5) begin
      in_mat = '0;
      set_elem(p / COLS, p % COLS, 77);
      cur_req = "R1";
      send(1'b0);
      cur_req = "R2";
      send(1'b1);
    end
    tick();

    // R5 / R6: back-to-back beats, axis flips every beat with new data
    cur_req = "R5";
    for (int b = 0; b < 6; b++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) set_elem(r, c, (b*7 + r*5 + c*11) % 200);
      in_valid = 1'b1;
      in_axis  = b[0];
      tick();
    end
    in_valid = 1'b0;
    tick();

    // R7: consumer stalls while a second beat waits
    cur_req = "R7";
    out_ready = 1'b0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_elem(r, c, r + c + 2);
    in_valid = 1'b1;
    in_axis  = 1'b1;
    tick();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_elem(r, c, 50 + r*c);
    in_axis = 1'b0;
    for (int s = 0; s < 4; s++) tick();
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
    tick();
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule